// File: doc/BRIEF.md
# Two-Queue SRAM Write Sequencer

This block empties two first-in first-out queues into a single synchronous SRAM that has no bus turnaround latency. All of its logic runs on the SRAM clock. Both queues present their empty and almost-empty flags already synchronised to that clock, along with a head entry that holds an address and a data word. The sequencer grants one queue per transaction and raises a registered one-cycle pop to it. In the next cycle it presents the popped address with the write strobe active. Two clocks after that address, it drives the matching data word onto the SRAM data bus.

A queue's empty flag only reflects a pop on the clock after the queue samples it. The sequencer therefore never trusts the flag in the cycle right after its own pop. It pops the same queue again in the next cycle only if that queue's almost-empty flag was low; otherwise it leaves one idle cycle. When both queues can be served, the grant alternates between them. A short data pipeline lets address cycles run on consecutive clocks while earlier data words are still in flight.

Top module: `sram_wr_sequencer`

## Requirements
- R1: A synchronous active-high reset clears both pops, the write strobe and the data-drive enable. After reset, queue 0 is preferred first.
- R2: A pop is raised only toward a queue whose empty flag was low at the deciding edge. It appears one clock after that flag is observed low.
- R3: At most one of the two pops is high in any cycle, and each pop lasts one cycle per granted entry.
- R4: One clock after a pop, the write strobe is high and the address bus carries the popped entry's address. The write strobe is low in every cycle that does not follow a pop.
- R5: The data-drive enable is high exactly two clocks after each write-strobe cycle and low otherwise. While it is high, the data output equals the data word of the address written two clocks earlier.
- R6: A pop to a queue in the cycle right after a pop to the same queue is raised only if that queue's almost-empty flag was low during the first pop. Otherwise at least one cycle without a pop to that queue follows.
- R7: When both queues are eligible at the same edge, the grant goes to the queue not granted most recently. With both loaded from reset, the grants run 0,1,0,1.
- R8: Every queued entry is written exactly once, and within each queue the addresses are written in queue order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | SRAM clock |
| rst | input | 1 | Synchronous reset, active high |
| q0_empty | input | 1 | Queue 0 holds no entry |
| q0_aempty | input | 1 | Queue 0 holds at most one entry |
| q0_pop | output | 1 | Pop request to queue 0 |
| q0_addr | input | AW | Queue 0 head address |
| q0_data | input | DW | Queue 0 head data |
| q1_empty | input | 1 | Queue 1 holds no entry |
| q1_aempty | input | 1 | Queue 1 holds at most one entry |
| q1_pop | output | 1 | Pop request to queue 1 |
| q1_addr | input | AW | Queue 1 head address |
| q1_data | input | DW | Queue 1 head data |
| sram_addr | output | AW | SRAM address |
| sram_we | output | 1 | SRAM write strobe |
| sram_dout | output | DW | SRAM write data |
| sram_doe | output | 1 | SRAM data-drive enable |

## Verification
The assertions assume that each queue behaves as a well-formed queue. Empty must be high exactly when the queue holds no entry, and almost-empty exactly when it holds at most one. Both flags must change only at the edge that samples a pop or a push, so the check that a pop never meets an empty queue depends on that timing. The bench queue models follow the same contract. Their flags are derived from an occupancy count that changes only at the clock edge. Pushes are made only while the sequencer is in reset or between scenarios, so every flag change comes from the sequencer's own pops.

// File: rtl/sram_wr_sequencer.sv
module sram_wr_sequencer #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          q0_empty,
  input  logic          q0_aempty,
  output logic          q0_pop,
  input  logic [AW-1:0] q0_addr,
  input  logic [DW-1:0] q0_data,
  input  logic          q1_empty,
  input  logic          q1_aempty,
  output logic          q1_pop,
  input  logic [AW-1:0] q1_addr,
  input  logic [DW-1:0] q1_data,
  output logic [AW-1:0] sram_addr,
  output logic          sram_we,
  output logic [DW-1:0] sram_dout,
  output logic          sram_doe
);

  localparam int LAG = 2;

  logic elig0, elig1, take0, take1, last1, popped;
  logic [DW-1:0] dpipe [LAG];
  logic [LAG-1:0] vpipe;

  assign elig0  = !q0_empty && (!q0_pop || !q0_aempty);
  assign elig1  = !q1_empty && (!q1_pop || !q1_aempty);
  assign take0  = elig0 && (!elig1 || last1);
  assign take1  = elig1 && !take0;
  assign popped = q0_pop || q1_pop;

  always_ff @(posedge clk) begin
    if (rst) begin
      q0_pop    <= 1'b0;
      q1_pop    <= 1'b0;
      last1     <= 1'b1;
      sram_we   <= 1'b0;
      sram_addr <= '0;
      vpipe     <= '0;
      sram_doe  <= 1'b0;
      sram_dout <= '0;
      for (int i = 0; i < LAG; i++) dpipe[i] <= '0;
    end else begin
      q0_pop  <= take0;
      q1_pop  <= take1;
      if (take0 || take1) last1 <= take1;
      sram_we <= popped;
      if (popped) begin
        sram_addr <= q1_pop ? q1_addr : q0_addr;
        dpipe[0]  <= q1_pop ? q1_data : q0_data;
      end
      for (int i = 1; i < LAG; i++) dpipe[i] <= dpipe[i-1];
      vpipe     <= {vpipe[LAG-2:0], popped};
      sram_dout <= dpipe[LAG-1];
      sram_doe  <= vpipe[LAG-1];
    end
  end

  assert_one_pop_R3: assert property (@(posedge clk) disable iff (rst)
    !(q0_pop && q1_pop));

  assert_pop_nonempty0_R2: assert property (@(posedge clk) disable iff (rst)
    q0_pop |-> !q0_empty);

  assert_pop_nonempty1_R2: assert property (@(posedge clk) disable iff (rst)
    q1_pop |-> !q1_empty);

  assert_b2b_pop0_R6: assert property (@(posedge clk) disable iff (rst)
    q0_pop && $past(q0_pop) |-> !$past(q0_aempty));

  assert_b2b_pop1_R6: assert property (@(posedge clk) disable iff (rst)
    q1_pop && $past(q1_pop) |-> !$past(q1_aempty));

  assert_we_after_pop_R4: assert property (@(posedge clk) disable iff (rst)
    popped |=> sram_we);

  assert_no_stray_we_R4: assert property (@(posedge clk) disable iff (rst)
    !popped |=> !sram_we);

  assert_data_lag_R5: assert property (@(posedge clk) disable iff (rst)
    sram_we |-> ##2 sram_doe);

  assert_doe_source_R5: assert property (@(posedge clk) disable iff (rst)
    sram_doe |-> $past(sram_we, 2));

endmodule

// File: tb/sram_wr_sequencer_bench.sv
module sram_wr_sequencer_bench;
  logic clk = 1'b0, rst = 1'b1;
  logic q0_empty, q0_aempty, q0_pop, q1_empty, q1_aempty, q1_pop;
  logic [7:0] q0_addr, q1_addr, sram_addr;
  logic [15:0] q0_data, q1_data, sram_dout;
  logic sram_we, sram_doe;

  int checks = 0, errors = 0;
  int cnt0 = 0, cnt1 = 0, head0 = 0, head1 = 0, add0 = 0, add1 = 0;
  bit clr = 1'b1;
  int wr0 = 0, wr1 = 0, writes = 0;
  int gseq [8];
  int gcnt = 0;
  bit h_we1 = 0, h_we2 = 0, p_pop0 = 0, p_pop1 = 0, p_ae0 = 0, p_ae1 = 0, p_any = 0;
  logic [7:0] h_a1 = 0, h_a2 = 0;

  always #10 clk = ~clk;

  function automatic logic [15:0] dfun(input logic [7:0] a);
    return {a ^ 8'h5A, a};
  endfunction

  assign q0_empty  = (cnt0 == 0);
  assign q0_aempty = (cnt0 <= 1);
  assign q1_empty  = (cnt1 == 0);
  assign q1_aempty = (cnt1 <= 1);
  assign q0_addr = {1'b0, 7'(head0)};
  assign q1_addr = {1'b1, 7'(head1)};
  assign q0_data = dfun(q0_addr);
  assign q1_data = dfun(q1_addr);

  sram_wr_sequencer u_sram_wr_sequencer (
    .clk(clk), .rst(rst),
    .q0_empty(q0_empty), .q0_aempty(q0_aempty), .q0_pop(q0_pop),
    .q0_addr(q0_addr), .q0_data(q0_data),
    .q1_empty(q1_empty), .q1_aempty(q1_aempty), .q1_pop(q1_pop),
    .q1_addr(q1_addr), .q1_data(q1_data),
    .sram_addr(sram_addr), .sram_we(sram_we),
    .sram_dout(sram_dout), .sram_doe(sram_doe));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (clr) begin
      cnt0 <= 0; cnt1 <= 0; head0 <= 0; head1 <= 0;
    end else begin
      cnt0 <= cnt0 + add0 - int'(q0_pop && cnt0 > 0);
      cnt1 <= cnt1 + add1 - int'(q1_pop && cnt1 > 0);
      if (q0_pop && cnt0 > 0) head0 <= head0 + 1;
      if (q1_pop && cnt1 > 0) head1 <= head1 + 1;
    end
  end

  always @(negedge clk) begin
    if (clr || rst) begin
      wr0 = 0; wr1 = 0; writes = 0; gcnt = 0;
      h_we1 = 0; h_we2 = 0; p_pop0 = 0; p_pop1 = 0; p_any = 0;
    end else begin
      chk(!(q0_pop && q1_pop), "R3 pops", int'(q0_pop) + int'(q1_pop), 1);
      if (q0_pop) chk(cnt0 >= 1, "R2 pop0 on empty", cnt0, 1);
      if (q1_pop) chk(cnt1 >= 1, "R2 pop1 on empty", cnt1, 1);
      if (q0_pop && p_pop0) chk(!p_ae0, "R6 back-to-back q0", int'(p_ae0), 0);
      if (q1_pop && p_pop1) chk(!p_ae1, "R6 back-to-back q1", int'(p_ae1), 0);
      chk(sram_we == p_any, "R4 we after pop", int'(sram_we), int'(p_any));
      chk(sram_doe == h_we2, "R5 doe timing", int'(sram_doe), int'(h_we2));
      if (sram_doe && h_we2)
        chk(sram_dout == dfun(h_a2), "R5 data", int'(sram_dout), int'(dfun(h_a2)));
      if (sram_we) begin
        writes++;
        if (sram_addr[7]) begin
          chk(int'(sram_addr[6:0]) == wr1, "R8 q1 order", int'(sram_addr[6:0]), wr1);
          wr1++;
        end else begin
          chk(int'(sram_addr[6:0]) == wr0, "R8 q0 order", int'(sram_addr[6:0]), wr0);
          wr0++;
        end
      end
      if ((q0_pop || q1_pop) && gcnt < 8) begin
        gseq[gcnt] = q1_pop ? 1 : 0;
        gcnt++;
      end
      h_we2 = h_we1; h_a2 = h_a1;
      h_we1 = sram_we; h_a1 = sram_addr;
      p_pop0 = q0_pop; p_pop1 = q1_pop; p_ae0 = q0_aempty; p_ae1 = q1_aempty;
      p_any = q0_pop || q1_pop;
    end
  end

  task automatic start(input int n0, input int n1);
    @(negedge clk);
    rst = 1'b1; clr = 1'b1;
    repeat (2) @(negedge clk);
    clr = 1'b0; add0 = n0; add1 = n1;
    @(negedge clk);
    add0 = 0; add1 = 0; rst = 1'b0;
  endtask

  localparam logic [11:0] VEC [6] = '{
    12'h101, 12'h011, 12'h112, 12'h404, 12'h235, 12'h66C
  };

  initial begin
    #(20 * 200000);
    chk(1'b0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk(!q0_pop && !q1_pop && !sram_we && !sram_doe, "R1 reset state",
        int'({q0_pop, q1_pop, sram_we, sram_doe}), 0);

    foreach (VEC[k]) begin
      start(int'(VEC[k][11:8]), int'(VEC[k][7:4]));
      repeat (60) @(negedge clk);
      chk(wr0 == int'(VEC[k][11:8]), "R8 q0 writes", wr0, int'(VEC[k][11:8]));
      chk(wr1 == int'(VEC[k][7:4]), "R8 q1 writes", wr1, int'(VEC[k][7:4]));
      chk(writes == int'(VEC[k][3:0]), "R8 total writes", writes, int'(VEC[k][3:0]));
      chk(cnt0 == 0 && cnt1 == 0, "R8 drained", cnt0 + cnt1, 0);
    end

    start(1, 0);
    @(negedge clk);
    chk(q0_pop == 1'b1, "R2 single pop", int'(q0_pop), 1);
    @(negedge clk);
    chk(q0_pop == 1'b0, "R6 no double pop", int'(q0_pop), 0);
    chk(sram_we && sram_addr == 8'h00, "R4 address", int'(sram_addr), 0);
    @(negedge clk);
    chk(!sram_we && !sram_doe, "R5 gap", int'({sram_we, sram_doe}), 0);
    @(negedge clk);
    chk(sram_doe && sram_dout == dfun(8'h00), "R5 data cycle", int'(sram_dout), int'(dfun(8'h00)));
    @(negedge clk);
    chk(!sram_doe, "R5 doe release", int'(sram_doe), 0);

    start(3, 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(q0_pop == 1'b1, "R6 sustained pops", int'(q0_pop), 1);
    end
    @(negedge clk);
    chk(q0_pop == 1'b0, "R6 stop at almost-empty", int'(q0_pop), 0);

    start(2, 2);
    repeat (6) @(negedge clk);
    chk(gcnt == 4, "R7 grant count", gcnt, 4);
    for (int i = 0; i < 4; i++)
      chk(gseq[i] == i % 2, "R7 alternation", gseq[i], i % 2);

    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(!q0_pop && !q1_pop && !sram_we && !sram_doe, "R1 reset mid-run",
        int'({q0_pop, q1_pop, sram_we, sram_doe}), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule